// File: doc/BRIEF.md
# DQS Delay Window Search Engine

This block calibrates the read-strobe timing of a DDR memory interface without software. On a pulse of `cal_go` it walks a two-level grid of settings. The outer level is a write-strobe shift, and the strobe-output shift always follows it at a fixed offset. The inner level is a strobe delay that is driven onto every byte lane at once.

For each grid point the engine holds the controller start line low while the settings change. It then raises start and waits for the delay line to lock and for the controller to report initialisation. After a programmable settling time it writes a fixed 64-word pattern through a simple word-wide memory port. It reads every word back several times. A point passes only if every read matches.

While sweeping, the engine keeps the longest run of consecutive passing delays. At the end it programs the best shift and the midpoint of that run. It goes through one more start/lock/init/settle cycle and then raises `cal_done`. A handshake timeout, or a sweep in which no point passes, ends with `cal_done` and `cal_err` both high.

Top module: `dqs_window_search`

## Requirements
- R1: After reset, `cal_done`, `cal_err`, `ctrl_start`, `mem_we` and `mem_re` are 0. `cfg_wr_shift` is 0, `cfg_out_shift` is SHIFT_OFS (32) and every lane delay field is 0.
- R2: The grid points are visited shift-major. The shift runs from SHIFT_LO to SHIFT_HI and, for each shift, the delay runs from DLY_LO to DLY_HI. Each point raises `ctrl_start` once. While it is high, `cfg_out_shift` equals `cfg_wr_shift` + 32 and all LANES fields of `cfg_lane_dly` (lane k at bits [k*DLYW +: DLYW]) carry the same delay.
- R3: The configuration outputs never change while `ctrl_start` stays high.
- R4: No memory access happens before `dll_lock` and then `init_done` have been seen high after `ctrl_start` rose. The first write follows at least SETTLE cycles after `init_done` rose.
- R5: Words are written at addresses 0 to NWORDS-1 in order. The base value of word a depends on a[5:4]: 0 gives 0x00000000, 1 gives 0xAAAAAAAA, 2 gives 0xA5A5A5A5 and 3 gives 0xAA55AA55. The word is the bitwise inverse of its base when the pair number a[3:1] is 1, 3, 4 or 6.
- R6: After the writes, the words are read in address order and each is read NREADS times in a row. The first mismatch ends the point. A failing point therefore makes addr*NREADS+rep+1 reads, and a passing point makes NWORDS*NREADS reads.
- R7: The pass run is cleared by a failing point and at the start of every new shift. Whenever a passing point brings the run to a length at least equal to the best so far, that run becomes the best, so a later run of equal length wins.
- R8: After the sweep, the engine programs the best run's shift and the delay (start+end)/2, rounded down. It raises `ctrl_start` again, waits for lock, init and settle, and then holds `cal_done`=1 and `cal_err`=0 with `ctrl_start` still high.
- R9: If no point passes, the engine sets `cal_done`=1 and `cal_err`=1 and returns the configuration outputs to their reset values.
- R10: If `dll_lock` or `init_done` stays low for POLL_MAX cycles of polling, the engine ends with `cal_done`=1, `cal_err`=1 and `ctrl_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_go | input | 1 | Pulse to begin a calibration run (accepted when idle or done) |
| ctrl_start | output | 1 | Start request to the memory controller |
| dll_lock | input | 1 | Delay line locked |
| init_done | input | 1 | Controller initialisation complete |
| cfg_wr_shift | output | SW | Write-strobe shift setting |
| cfg_out_shift | output | SW | Strobe-output shift setting, write shift plus offset |
| cfg_lane_dly | output | LANES*DLYW | Strobe delay for every byte lane |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data is expected the next cycle |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_re` |
| cal_done | output | 1 | Calibration finished |
| cal_err | output | 1 | Calibration failed (no passing point or timeout) |

## Verification
The assertions assume three things about the environment. The controller keeps `init_done` high for as long as `ctrl_start` is high once initialisation has finished. `dll_lock` and `init_done` drop when start drops. Read data is returned the cycle after `mem_re` and is held until the next read. The bench's controller model follows these rules: it derives lock and init from `ctrl_start` with fixed latencies and clears both as soon as start falls. Its memory model updates read data only on a read strobe. Pass or fail for each grid point comes from a per-shift mask. A failing point corrupts one chosen repetition of one chosen word, so both the reread count and the early stop on a mismatch are visible in the number of reads.

// File: rtl/dqs_window_search.sv
module dqs_window_search #(
  parameter int SHIFT_LO  = 64,
  parameter int SHIFT_HI  = 95,
  parameter int SHIFT_OFS = 32,
  parameter int DLY_LO    = 1,
  parameter int DLY_HI    = 63,
  parameter int LANES     = 9,
  parameter int NWORDS    = 64,
  parameter int NREADS    = 10,
  parameter int POLL_MAX  = 65535,
  parameter int SETTLE    = 10000,
  parameter int DW        = 32,
  parameter int SW        = 7,
  parameter int DLYW      = 7,
  parameter int AW        = $clog2(NWORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cal_go,
  output logic                  ctrl_start,
  input  logic                  dll_lock,
  input  logic                  init_done,
  output logic [SW-1:0]         cfg_wr_shift,
  output logic [SW-1:0]         cfg_out_shift,
  output logic [LANES*DLYW-1:0] cfg_lane_dly,
  output logic                  mem_we,
  output logic                  mem_re,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  cal_done,
  output logic                  cal_err
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int TW = $clog2(SETTLE + 1);
  localparam int RW = $clog2(NREADS + 1);

  typedef enum logic [3:0] {S_IDLE, S_PROG, S_LOCK, S_INIT, S_SETTLE,
                            S_WR, S_RD, S_CMP, S_EVAL, S_FIN, S_DONE} st_t;

  st_t             st;
  logic [SW-1:0]   shift, bshift;
  logic [DLYW-1:0] dly, run, rstart, best, bstart, bend;
  logic [DLYW-1:0] run_n, rs_n, mid;
  logic [AW-1:0]   addr;
  logic [RW-1:0]   rep;
  logic [PW-1:0]   poll;
  logic [TW-1:0]   tmr;
  logic            pass, final_ph, start, done, err;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    logic [5:0]    i;
    logic [DW-1:0] b;
    i = 6'(a);
    case (i[5:4])
      2'd0:    b = '0;
      2'd1:    b = {(DW/8){8'hAA}};
      2'd2:    b = {(DW/8){8'hA5}};
      default: b = {(DW/16){16'hAA55}};
    endcase
    return (i[1] ^ i[3]) ? ~b : b;
  endfunction

  always_comb begin
    run_n = pass ? run + 1'b1 : '0;
    rs_n  = (pass && run == '0) ? dly : rstart;
    mid   = DLYW'(({1'b0, bstart} + {1'b0, bend}) >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; shift <= '0; bshift <= '0; dly <= '0; run <= '0;
      rstart <= '0; best <= '0; bstart <= '0; bend <= '0; addr <= '0;
      rep <= '0; poll <= '0; tmr <= '0; pass <= 1'b0; final_ph <= 1'b0;
      start <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (cal_go) begin
          done <= 1'b0; err <= 1'b0; start <= 1'b0; best <= '0; run <= '0;
          shift <= SW'(SHIFT_LO); dly <= DLYW'(DLY_LO); final_ph <= 1'b0;
          st <= S_PROG;
        end
        S_PROG: begin start <= 1'b1; poll <= '0; st <= S_LOCK; end
        S_LOCK:
          if (dll_lock) begin poll <= '0; st <= S_INIT; end
          else if (poll == PW'(POLL_MAX - 1)) begin
            start <= 1'b0; done <= 1'b1; err <= 1'b1; st <= S_DONE;
          end else poll <= poll + 1'b1;
        S_INIT:
          if (init_done) begin tmr <= '0; st <= S_SETTLE; end
          else if (poll == PW'(POLL_MAX - 1)) begin
            start <= 1'b0; done <= 1'b1; err <= 1'b1; st <= S_DONE;
          end else poll <= poll + 1'b1;
        S_SETTLE:
          if (tmr == TW'(SETTLE - 1)) begin
            if (final_ph) begin done <= 1'b1; st <= S_DONE; end
            else begin addr <= '0; st <= S_WR; end
          end else tmr <= tmr + 1'b1;
        S_WR:
          if (addr == AW'(NWORDS - 1)) begin addr <= '0; rep <= '0; st <= S_RD; end
          else addr <= addr + 1'b1;
        S_RD: st <= S_CMP;
        S_CMP:
          if (mem_rdata != pat(addr)) begin pass <= 1'b0; st <= S_EVAL; end
          else if (rep == RW'(NREADS - 1)) begin
            rep <= '0;
            if (addr == AW'(NWORDS - 1)) begin pass <= 1'b1; st <= S_EVAL; end
            else begin addr <= addr + 1'b1; st <= S_RD; end
          end else begin rep <= rep + 1'b1; st <= S_RD; end
        S_EVAL: begin
          start  <= 1'b0;
          rstart <= rs_n;
          if (pass && run_n >= best) begin
            best <= run_n; bshift <= shift; bstart <= rs_n; bend <= dly;
          end
          if (dly == DLYW'(DLY_HI)) begin
            run <= '0; dly <= DLYW'(DLY_LO);
            if (shift == SW'(SHIFT_HI)) st <= S_FIN;
            else begin shift <= shift + 1'b1; st <= S_PROG; end
          end else begin
            run <= run_n; dly <= dly + 1'b1; st <= S_PROG;
          end
        end
        S_FIN:
          if (best == '0) begin
            shift <= '0; dly <= '0; done <= 1'b1; err <= 1'b1; st <= S_DONE;
          end else begin
            shift <= bshift; dly <= mid; final_ph <= 1'b1; st <= S_PROG;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ctrl_start    = start;
  assign cfg_wr_shift  = shift;
  assign cfg_out_shift = shift + SW'(SHIFT_OFS);
  assign cfg_lane_dly  = {LANES{dly}};
  assign mem_we        = (st == S_WR);
  assign mem_re        = (st == S_RD);
  assign mem_addr      = addr;
  assign mem_wdata     = pat(addr);
  assign cal_done      = done;
  assign cal_err       = err;

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_start && $past(ctrl_start)) |-> ($stable(cfg_wr_shift) && $stable(cfg_lane_dly)));
  // R4
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (ctrl_start && init_done));
  // R8
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !cal_err) |-> (cfg_lane_dly[DLYW-1:0] >= DLYW'(DLY_LO) &&
                                cfg_lane_dly[DLYW-1:0] <= DLYW'(DLY_HI)));
  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |-> (cal_done && !ctrl_start));
endmodule

// File: tb/sim_dqs_window_search.sv
module sim_dqs_window_search;
  localparam int SLO = 2, SHI = 4, DLO = 1, DHI = 10;
  localparam int NW = 64, NR = 3, POLL = 40, SET = 6;
  localparam int NPTS = (SHI - SLO + 1) * (DHI - DLO + 1);

  logic clk = 1'b0, rst_n = 1'b0, cal_go = 1'b0;
  logic dll_lock = 1'b0, init_done = 1'b0;
  logic ctrl_start, mem_we, mem_re, cal_done, cal_err;
  logic [6:0] cfg_wr_shift, cfg_out_shift;
  logic [62:0] cfg_lane_dly;
  logic [5:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  dqs_window_search #(.SHIFT_LO(SLO), .SHIFT_HI(SHI), .DLY_LO(DLO), .DLY_HI(DHI),
    .NWORDS(NW), .NREADS(NR), .POLL_MAX(POLL), .SETTLE(SET)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_go(cal_go), .ctrl_start(ctrl_start),
    .dll_lock(dll_lock), .init_done(init_done), .cfg_wr_shift(cfg_wr_shift),
    .cfg_out_shift(cfg_out_shift), .cfg_lane_dly(cfg_lane_dly), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cal_done(cal_done), .cal_err(cal_err));

  always #10 clk = ~clk;

  typedef struct { int sh; int d; bit err; bit tmo; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic [9:0] mask [3];
  bit lock_never = 0, init_never = 0;
  logic [31:0] mem [64];
  int rc [64];
  int cyc = 0, pt_idx = 0, rd_cnt, fa, fr, init_cyc = 0, rise_cyc = 0, lcnt = 0, icnt = 0;
  bit sweep_pt = 0, cur_pass, wr_bad, first_wr, chg, corrupt;
  logic p_start = 0, p_done = 0;
  logic [6:0] p_sh;
  logic [62:0] p_lanes;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bpat(input int a);
    logic [31:0] b;
    int p;
    case ((a >> 4) & 3)
      0: b = 32'h00000000;
      1: b = 32'hAAAAAAAA;
      2: b = 32'hA5A5A5A5;
      default: b = 32'hAA55AA55;
    endcase
    p = (a >> 1) & 7;
    return (p == 1 || p == 3 || p == 4 || p == 6) ? ~b : b;
  endfunction

  task automatic expect_of(output int sh, output int d, output bit err);
    int best = 0, run = 0, st = 0, bs = 0, be = 0, bsh = 0;
    for (int s = 0; s < 3; s++) begin
      run = 0;
      for (int k = DLO; k <= DHI; k++) begin
        if (mask[s][k-1]) begin
          if (run == 0) st = k;
          run++;
          if (run >= best) begin best = run; bsh = s + SLO; bs = st; be = k; end
        end else run = 0;
      end
    end
    err = (best == 0); sh = bsh; d = (bs + be) / 2;
  endtask

  task automatic run_cal(input string tag, input bit tmo);
    exp_t e;
    expect_of(e.sh, e.d, e.err);
    if (tmo) e.err = 1;
    e.tmo = tmo; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #2 cal_go = 1'b1;
    @(posedge clk); #2 cal_go = 1'b0;
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cal_go) pt_idx = 0;
      if (ctrl_start && !p_start) begin
        sweep_pt = (pt_idx < NPTS) && !lock_never && !init_never;
        if (pt_idx < NPTS) begin
          chk(cfg_wr_shift == 7'(SLO + pt_idx / 10), "R2", "sweep shift", cfg_wr_shift, SLO + pt_idx / 10);
          chk(cfg_lane_dly[6:0] == 7'(DLO + pt_idx % 10), "R2", "sweep delay", cfg_lane_dly[6:0], DLO + pt_idx % 10);
          chk(cfg_out_shift == cfg_wr_shift + 7'd32, "R2", "out shift", cfg_out_shift, cfg_wr_shift + 32);
          chk(cfg_lane_dly == {9{cfg_lane_dly[6:0]}}, "R2", "lane replication", cfg_lane_dly[13:7], cfg_lane_dly[6:0]);
        end
        if (sweep_pt) begin
          cur_pass = mask[cfg_wr_shift - SLO][cfg_lane_dly[6:0] - 1];
          fa = (cfg_wr_shift + cfg_lane_dly[6:0]) % NW;
          fr = (cfg_wr_shift * 3 + cfg_lane_dly[6:0]) % NR;
        end
        rd_cnt = 0; wr_bad = 0; first_wr = 1; chg = 0; rise_cyc = cyc;
        for (int i = 0; i < 64; i++) rc[i] = 0;
        pt_idx++;
      end
      if (ctrl_start && p_start && (cfg_wr_shift != p_sh || cfg_lane_dly != p_lanes)) chg = 1;
      if (!ctrl_start && p_start) begin
        chk(!chg, "R3", "settings moved while start high", chg, 0);
        if (sweep_pt) begin
          chk(rd_cnt == (cur_pass ? NW * NR : fa * NR + fr + 1), "R6", "reads per point",
              rd_cnt, cur_pass ? NW * NR : fa * NR + fr + 1);
          chk(!wr_bad, "R5", "pattern words", wr_bad, 0);
        end
        sweep_pt = 0;
      end
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        if (mem_wdata != bpat(mem_addr)) wr_bad = 1;
        if (first_wr) begin
          chk(cyc - init_cyc >= SET, "R4", "settle before first write", cyc - init_cyc, SET);
          first_wr = 0;
        end
      end
      if (mem_re) begin
        corrupt = sweep_pt && !cur_pass && (mem_addr == fa) && (rc[mem_addr] == fr);
        mem_rdata = mem[mem_addr] ^ {31'b0, corrupt};
        rc[mem_addr]++;
        rd_cnt++;
      end
      if (cal_done && !p_done) begin
        if (q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cal_err == e.err, e.tag, "error flag", cal_err, e.err);
          if (!e.err) begin
            chk(cfg_wr_shift == 7'(e.sh), e.tag, "window shift", cfg_wr_shift, e.sh);
            for (int k = 0; k < 9; k++)
              chk(cfg_lane_dly[k*7 +: 7] == 7'(e.d), e.tag, "window delay", cfg_lane_dly[k*7 +: 7], e.d);
            chk(cfg_out_shift == 7'(e.sh + 32), "R8", "final out shift", cfg_out_shift, e.sh + 32);
            chk(ctrl_start == 1'b1, "R8", "final start held", ctrl_start, 1);
          end else if (!e.tmo) begin
            chk(cfg_wr_shift == 0, "R9", "shift restored", cfg_wr_shift, 0);
            chk(cfg_out_shift == 7'd32, "R9", "out shift restored", cfg_out_shift, 32);
            chk(cfg_lane_dly == '0, "R9", "delay restored", cfg_lane_dly[6:0], 0);
          end else begin
            chk(ctrl_start == 1'b0, "R10", "start dropped", ctrl_start, 0);
            chk(cyc - rise_cyc >= POLL, "R10", "poll length", cyc - rise_cyc, POLL);
          end
        end
      end
      if (ctrl_start) begin
        lcnt++;
        dll_lock = !lock_never && lcnt >= 3;
        if (dll_lock) icnt++;
        if (!init_never && icnt >= 2 && !init_done) init_cyc = cyc;
        init_done = !init_never && icnt >= 2;
      end else begin
        lcnt = 0; icnt = 0; dll_lock = 1'b0; init_done = 1'b0;
      end
      p_start = ctrl_start; p_sh = cfg_wr_shift; p_lanes = cfg_lane_dly; p_done = cal_done;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!cal_done && !cal_err && !ctrl_start, "R1", "reset status", {cal_done, cal_err, ctrl_start}, 0);
    chk(cfg_wr_shift == 0 && cfg_lane_dly == '0, "R1", "reset settings", cfg_lane_dly[6:0], 0);
    chk(cfg_out_shift == 7'd32, "R1", "reset out shift", cfg_out_shift, 32);
    chk(!mem_we && !mem_re, "R1", "no idle access", {mem_we, mem_re}, 0);
    // R7 longest run in the middle shift
    mask[0] = 10'h03C; mask[1] = 10'h0FE; mask[2] = 10'h070;
    run_cal("R7", 0);
    // R7 equal runs in different shifts: later wins
    mask[0] = 10'h00F; mask[1] = 10'h1E0; mask[2] = 10'h000;
    run_cal("R7", 0);
    // R7 equal runs within one shift: later wins
    mask[0] = 10'h000; mask[1] = 10'h0E7; mask[2] = 10'h000;
    run_cal("R7", 0);
    // R7 run cleared at a new shift
    mask[0] = 10'h380; mask[1] = 10'h003; mask[2] = 10'h000;
    run_cal("R7", 0);
    // R8 all points pass
    mask[0] = 10'h3FF; mask[1] = 10'h3FF; mask[2] = 10'h3FF;
    run_cal("R8", 0);
    // R9 nothing passes
    mask[0] = 10'h000; mask[1] = 10'h000; mask[2] = 10'h000;
    run_cal("R9", 0);
    // R10 lock and init timeouts
    lock_never = 1;
    run_cal("R10", 1);
    lock_never = 0; init_never = 1;
    run_cal("R10", 1);
    init_never = 0;
    mask[0] = 10'h03C; mask[1] = 10'h0FE; mask[2] = 10'h070;
    run_cal("R7", 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule